// File: doc/BRIEF.md
# 64-bit Periodic Interval Timer

A memory-mapped timer peripheral. It has an up-counter, a compare (period) value of the same width, a 4-bit prescaler, and a choice of continuous or one-shot operation. Software reaches it through a simple 32-bit register bus with separate read and write strobes. A level interrupt reports a period match. The counter and the period are each wider than the bus, so both are split into a low half and a high half. Ordered access rules make a 64-bit access look atomic: a read of the counter low half freezes the high half, and a write to the period high half waits until the low half is written.

After a start command the counter advances once every prescaler+1 clock cycles. When it equals the period it returns to zero and sets a status flag. In continuous mode it keeps running. In one-shot mode it halts in a finished state. A start command is ignored while the counter runs. It is also ignored in the finished state until a software reset clears that state, or until a new period is committed with the reconfigure bit set. A clock-select bit is stored and read back but has no other effect: one clock drives everything.

The counter width `CNT_W` is a parameter with a default of 64. Each half is `CNT_W/2` bits wide and sits in the low bits of the bus word.

Top module: `pit64_timer`

## Requirements
- R1: After reset the mode, interrupt-enable, status and counter registers read 0, the period reads all ones, and `irq` is 0.
- R2: Register offsets are: control 0x00 (write-only, reads 0), mode 0x04, period low 0x08, period high 0x0C, interrupt enable 0x10 (bit 0), status 0x1C (bit 0), counter low 0x20 and counter high 0x24. The mode fields are continuous at bit 0, clock-select at bit 3, reconfigure at bit 4 and prescaler at bits 11:8; the other mode bits read 0.
- R3: A start is a write to control with bit 0 set, accepted at edge E0 from the idle state. The counter value sampled by a read at edge Er is then floor((Er-E0-1)/(pres+1)) modulo (period+1) in continuous mode.
- R4: On the advance where the counter equals the period, the counter becomes 0 and the status flag is set. In continuous mode this repeats on every match.
- R5: In one-shot mode the counter halts at 0 after its first match. A later start, or a period commit with reconfigure clear, does not restart it.
- R6: A start command issued while the counter is running has no effect on the count sequence.
- R7: A write to the period high half only takes effect when the period low half is written. Until then, reads of the period return the old committed value.
- R8: A read of the counter low half captures the counter high half in the same cycle. A later read of the high half returns that captured value.
- R9: With reconfigure set, committing a period while the counter is halted after a one-shot match makes it idle again, and the next start runs it from 0.
- R10: A write to control with bit 8 set stops the counter and clears the counter, the status flag and the interrupt enable.
- R11: `irq` equals the status flag ANDed with the enable bit. A status read returns the flag and then clears it.
- R12: If a match falls in the same cycle as a status read, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counter |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the strobe |
| irq | output | 1 | Level interrupt: status flag AND enable |

## Verification
Read data is registered at the strobe edge, so the bench samples it at the falling edge that follows. That value reflects the state held just before the strobe edge. Expected counts therefore use Er-E0-1 edges after the start edge E0, with one advance per prescaler+1 of those edges. The status flag and `irq` change on the edge of the matching advance and are visible from the next falling edge. Every check samples at a falling edge and compares against counts the bench derives from the edge indices it recorded for each bus access. The bench is built with a 16-bit counter, so the captured high half changes within a few hundred cycles and the atomicity of the split read can be exercised.

// File: rtl/pit64_pkg.sv
// Shared constants for the interval timer: register offsets, bit
// positions and the run-state type. Assumes byte addressing on a 6-bit bus.
package pit64_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_PER_LO = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_PER_HI = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 6'h24;

    localparam int BIT_GO     = 0;
    localparam int BIT_CLR    = 8;
    localparam int BIT_CONT   = 0;
    localparam int BIT_CLKSEL = 3;
    localparam int BIT_RECONF = 4;
    localparam int BIT_PRES   = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_e;
endpackage

// File: rtl/pit64_prescale.sv
// Prescaler: gives a one-cycle advance pulse every pres+1 cycles while
// the counter runs. Assumes the divider restarts from 0 whenever run drops.
module pit64_prescale #(
    parameter int PRES_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [PRES_W-1:0] pres_i,
    output logic              tick_o
);
    logic [PRES_W-1:0] div_q;

    assign tick_o = run_i && (div_q >= pres_i);

    // Divider count: cleared when halted or on each advance pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || tick_o) div_q <= '0;
        else                            div_q <= div_q + 1'b1;
    end

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && pres_i != '0) |=> (!tick_o || pres_i == '0));
endmodule

// File: rtl/pit64_core.sv
// Counter core: holds the run state and the up-counter, detects the
// period match and applies one-shot halting. Assumes at most one of
// start, clear and rearm per cycle matters, with clear taking priority.
module pit64_core
    import pit64_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             clear_i,
    input  logic             rearm_i,
    input  logic             cont_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o,
    output logic             run_o
);
    run_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;

    assign match_o = tick_i && (cnt_q == period_i);
    assign run_o   = (st_q == ST_RUN);
    assign cnt_o   = cnt_q;

    // Run-state sequencing: idle -> run -> done (one-shot) -> idle on rearm.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start_i)             st_q <= ST_RUN;
                ST_RUN:  if (match_o && !cont_i)  st_q <= ST_DONE;
                ST_DONE: if (rearm_i)             st_q <= ST_IDLE;
                default:                          st_q <= ST_IDLE;
            endcase
        end
    end

    // Counter: advances on each tick and wraps to zero on a match.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (tick_i)       cnt_q <= match_o ? '0 : cnt_q + 1'b1;
    end

    // R5
    done_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE) |-> (cnt_q == '0));
    // R6
    run_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !match_o && !clear_i) |=> (st_q == ST_RUN));
endmodule

// File: rtl/pit64_regs.sv
// Register file: decodes the 32-bit bus and holds the mode, the period
// with its pending high half, the interrupt enable, the status flag and
// the captured counter high half. Read data is registered. Assumes
// CNT_W is even and at most 64.
module pit64_regs
    import pit64_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int PRES_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              match_i,
    output logic              start_o,
    output logic              clear_o,
    output logic              rearm_o,
    output logic              cont_o,
    output logic [PRES_W-1:0] pres_o,
    output logic [CNT_W-1:0]  period_o,
    output logic              irq_o
);
    localparam int HALF_W = CNT_W / 2;

    logic              cont_q, clksel_q, reconf_q;
    logic [PRES_W-1:0] pres_q;
    logic [CNT_W-1:0]  per_q;
    logic [HALF_W-1:0] pend_hi_q, cap_hi_q;
    logic              ien_q, flag_q;
    logic [31:0]       rd_mux, rdata_q;
    logic              wr_ctrl, wr_lo, rd_stat, rd_cnt_lo;
    logic              unused_wdata_bits;

    assign unused_wdata_bits = ^bus_wdata[31:12];

    assign wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_lo     = bus_wr && (bus_addr == OFS_PER_LO);
    assign rd_stat   = bus_rd && (bus_addr == OFS_STAT);
    assign rd_cnt_lo = bus_rd && (bus_addr == OFS_CNT_LO);

    assign start_o  = wr_ctrl && bus_wdata[BIT_GO];
    assign clear_o  = wr_ctrl && bus_wdata[BIT_CLR];
    assign rearm_o  = wr_lo && reconf_q;
    assign cont_o   = cont_q;
    assign pres_o   = pres_q;
    assign period_o = per_q;
    assign irq_o    = flag_q && ien_q;
    assign bus_rdata = rdata_q;

    // Mode register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_q <= 1'b0; clksel_q <= 1'b0; reconf_q <= 1'b0; pres_q <= '0;
        end else if (bus_wr && bus_addr == OFS_MODE) begin
            cont_q   <= bus_wdata[BIT_CONT];
            clksel_q <= bus_wdata[BIT_CLKSEL];
            reconf_q <= bus_wdata[BIT_RECONF];
            pres_q   <= bus_wdata[BIT_PRES +: PRES_W];
        end
    end

    // Period: high half waits in a holding register until the low half commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q     <= '1;
            pend_hi_q <= '1;
        end else begin
            if (bus_wr && bus_addr == OFS_PER_HI) pend_hi_q <= bus_wdata[HALF_W-1:0];
            if (wr_lo) per_q <= {pend_hi_q, bus_wdata[HALF_W-1:0]};
        end
    end

    // Interrupt enable: software write, cleared by the software reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_o)                    ien_q <= 1'b0;
        else if (bus_wr && bus_addr == OFS_IEN)   ien_q <= bus_wdata[0];
    end

    // Status flag: set by a match, cleared by a read unless a match coincides.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_o) flag_q <= 1'b0;
        else if (match_i)      flag_q <= 1'b1;
        else if (rd_stat)      flag_q <= 1'b0;
    end

    // Counter high half frozen at the moment the low half is read.
    always_ff @(posedge clk) begin
        if (!rst_n)         cap_hi_q <= '0;
        else if (rd_cnt_lo) cap_hi_q <= cnt_i[CNT_W-1:HALF_W];
    end

    // Read data selection by offset.
    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFS_MODE: begin
                rd_mux[BIT_CONT]             = cont_q;
                rd_mux[BIT_CLKSEL]           = clksel_q;
                rd_mux[BIT_RECONF]           = reconf_q;
                rd_mux[BIT_PRES +: PRES_W]   = pres_q;
            end
            OFS_PER_LO: rd_mux[HALF_W-1:0] = per_q[HALF_W-1:0];
            OFS_PER_HI: rd_mux[HALF_W-1:0] = per_q[CNT_W-1:HALF_W];
            OFS_IEN:    rd_mux[0]          = ien_q;
            OFS_STAT:   rd_mux[0]          = flag_q;
            OFS_CNT_LO: rd_mux[HALF_W-1:0] = cnt_i[HALF_W-1:0];
            OFS_CNT_HI: rd_mux[HALF_W-1:0] = cap_hi_q;
            default:    rd_mux = '0;
        endcase
    end

    // Registered read data, zero when no read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
        else             rdata_q <= '0;
    end

    // R10
    sw_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> (!flag_q && !ien_q));
    // R12
    match_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && !clear_o) |=> flag_q);
    // R11
    stat_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !match_i) |=> !flag_q);
    // R8
    hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt_lo |=> (cap_hi_q == $past(cnt_i[CNT_W-1:HALF_W])));
endmodule

// File: rtl/pit64_timer.sv
// Top of the interval timer: joins the register file, the prescaler and
// the counter core. One clock drives all of it; the clock-select mode bit
// is storage only.
module pit64_timer
    import pit64_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int PRES_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0]  cnt, period;
    logic [PRES_W-1:0] pres;
    logic              match, run, tick, start, clear, rearm, cont;

    pit64_regs #(.CNT_W(CNT_W), .PRES_W(PRES_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_i(cnt), .match_i(match), .start_o(start), .clear_o(clear),
        .rearm_o(rearm), .cont_o(cont), .pres_o(pres), .period_o(period),
        .irq_o(irq)
    );

    pit64_prescale #(.PRES_W(PRES_W)) u_prescale (
        .clk(clk), .rst_n(rst_n), .run_i(run), .pres_i(pres), .tick_o(tick)
    );

    pit64_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start),
        .clear_i(clear), .rearm_i(rearm), .cont_i(cont), .period_i(period),
        .cnt_o(cnt), .match_o(match), .run_o(run)
    );
endmodule

// File: tb/pit64_timer_bench.sv
`timescale 1ns/1ps
module pit64_timer_bench;
    import pit64_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pit64_timer #(.CNT_W(16), .PRES_W(4)) u_pit64_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [5:0] a, input logic [31:0] d, output int e);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        e = cyc;
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [5:0] a, output logic [31:0] d, output int e);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        e = cyc;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic longint advances(input int e0, input int er, input int p);
        return longint'((er - e0 - 1) / (p + 1));
    endfunction

    function automatic longint cont_count(input int e0, input int er, input int p, input int per);
        return advances(e0, er, p) % (per + 1);
    endfunction

    function automatic longint oneshot_count(input int e0, input int er, input int p, input int per);
        longint t = advances(e0, er, p);
        return (t >= per + 1) ? 0 : t;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int e, e0, er, es;
        void'($urandom(32'h5eed));
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 irq", irq, 0);
        bread(OFS_MODE, d, e);   chk("R1 mode", d, 0);
        bread(OFS_STAT, d, e);   chk("R1 stat", d, 0);
        bread(OFS_CNT_LO, d, e); chk("R1 cnt", d, 0);
        bread(OFS_PER_LO, d, e); chk("R1 period", d, 32'hFF);

        // R7 pending high half
        bwrite(OFS_PER_HI, 32'h12, e);
        bread(OFS_PER_HI, d, e); chk("R7 hi pending", d, 32'hFF);
        bwrite(OFS_PER_LO, 32'h34, e);
        bread(OFS_PER_HI, d, e); chk("R7 hi committed", d, 32'h12);
        bread(OFS_PER_LO, d, e); chk("R7 lo committed", d, 32'h34);

        // R2 mode fields and offsets
        bwrite(OFS_MODE, 32'hFFFF_FFFF, e);
        bread(OFS_MODE, d, e); chk("R2 mode mask", d, 32'hF19);
        bread(OFS_CTRL, d, e); chk("R2 ctrl reads 0", d, 0);
        bwrite(OFS_MODE, 32'h0000_0008, e);
        bread(OFS_MODE, d, e); chk("R2 clksel", d, 32'h8);

        // R3 R4 R6 R11 random continuous runs
        for (int i = 0; i < 10; i++) begin
            int p, per, w;
            p = $urandom % 4; per = 2 + $urandom % 19; w = 6 + $urandom % 60;
            bwrite(OFS_CTRL, 32'h100, e);
            bwrite(OFS_MODE, (p << 8) | 1, e);
            bwrite(OFS_PER_HI, 0, e);
            bwrite(OFS_PER_LO, per, e);
            bwrite(OFS_CTRL, 32'h1, e0);
            idle(w / 2);
            bwrite(OFS_CTRL, 32'h1, e);   // R6 start while running
            idle(w / 2);
            bread(OFS_CNT_LO, d, er);
            chk("R3 R6 count", d, cont_count(e0, er, p, per));
            bread(OFS_STAT, d, es);
            chk("R4 flag", d, (advances(e0, es, p) >= per + 1) ? 1 : 0);
            chk("R11 irq masked", irq, 0);
        end

        // R8 atomic split read
        bwrite(OFS_CTRL, 32'h100, e);
        bwrite(OFS_MODE, 32'h1, e);
        bwrite(OFS_PER_HI, 32'hFF, e);
        bwrite(OFS_PER_LO, 32'hFF, e);
        bwrite(OFS_CTRL, 32'h1, e0);
        idle(700);
        bread(OFS_CNT_LO, d, er);
        chk("R8 low half", d, (er - e0 - 1) & 32'hFF);
        idle(300);
        bread(OFS_CNT_HI, d, e);
        chk("R8 captured high", d, (er - e0 - 1) >> 8);

        // R5 R9 one-shot and reconfigure
        bwrite(OFS_CTRL, 32'h100, e);
        bwrite(OFS_MODE, 32'h0, e);
        bwrite(OFS_PER_HI, 0, e);
        bwrite(OFS_PER_LO, 5, e);
        bwrite(OFS_CTRL, 32'h1, e0);
        idle(3);
        bread(OFS_CNT_LO, d, er); chk("R5 mid count", d, oneshot_count(e0, er, 0, 5));
        idle(20);
        bread(OFS_CNT_LO, d, er); chk("R5 halted", d, 0);
        bread(OFS_STAT, d, e);    chk("R5 flag", d, 1);
        bwrite(OFS_CTRL, 32'h1, e);
        idle(5);
        bread(OFS_CNT_LO, d, e);  chk("R5 start ignored", d, 0);
        bwrite(OFS_PER_HI, 0, e);
        bwrite(OFS_PER_LO, 3, e);
        bwrite(OFS_CTRL, 32'h1, e);
        idle(2);
        bread(OFS_CNT_LO, d, e);  chk("R5 commit no rearm", d, 0);
        bwrite(OFS_MODE, 32'h10, e);
        bwrite(OFS_PER_HI, 0, e);
        bwrite(OFS_PER_LO, 3, e);
        bwrite(OFS_CTRL, 32'h1, e0);
        idle(2);
        bread(OFS_CNT_LO, d, er); chk("R9 rerun", d, oneshot_count(e0, er, 0, 3));
        idle(20);
        bread(OFS_CNT_LO, d, e);  chk("R9 halted again", d, 0);

        // R11 interrupt and read-to-clear
        bwrite(OFS_CTRL, 32'h100, e);
        bwrite(OFS_MODE, 32'h0, e);
        bwrite(OFS_PER_HI, 0, e);
        bwrite(OFS_PER_LO, 3, e);
        bwrite(OFS_IEN, 32'h1, e);
        chk("R11 irq before", irq, 0);
        bwrite(OFS_CTRL, 32'h1, e0);
        idle(10);
        chk("R11 irq raised", irq, 1);
        bread(OFS_STAT, d, e); chk("R11 stat", d, 1);
        chk("R11 irq cleared", irq, 0);
        bread(OFS_STAT, d, e); chk("R11 stat cleared", d, 0);

        // R12 match coinciding with status read
        bwrite(OFS_CTRL, 32'h100, e);
        bwrite(OFS_MODE, 32'h1, e);
        bwrite(OFS_PER_HI, 0, e);
        bwrite(OFS_PER_LO, 0, e);
        bwrite(OFS_CTRL, 32'h1, e0);
        idle(3);
        bread(OFS_STAT, d, e); chk("R12 first", d, 1);
        bread(OFS_STAT, d, e); chk("R12 match wins", d, 1);

        // R10 software reset
        bwrite(OFS_IEN, 32'h1, e);
        idle(2);
        chk("R10 irq before", irq, 1);
        bwrite(OFS_CTRL, 32'h100, e);
        chk("R10 irq", irq, 0);
        bread(OFS_CNT_LO, d, e); chk("R10 cnt", d, 0);
        bread(OFS_STAT, d, e);   chk("R10 stat", d, 0);
        bread(OFS_IEN, d, e);    chk("R10 ien", d, 0);
        idle(10);
        bread(OFS_CNT_LO, d, e); chk("R10 stopped", d, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule